// File: doc/BRIEF.md
# Amplifier Offset Trim Calibration Sequencer

This block runs the offset calibration of an amplifier whose rail-to-rail input stage has two differential pairs, an N pair and a P pair, each with its own 5-bit trim code. One pulse on `start_i` launches the whole procedure. The sequencer turns the amplifier on, switches to user trim, ties both amplifier inputs to the internal reference, and then selects the reference level for the pair under calibration. It then raises that pair's trim code one step at a time from zero. After each step it waits a programmable settling time and reads the comparator status flag. A flag of 1 means the non-inverting input sits above the inverting input. The code at which the flag first reads low is kept.

The N pair is calibrated first, against the high reference (90 % of supply). The P pair follows, against the low reference (10 % of supply). At the end, calibration mode is switched off. User trim stays on, with both stored codes driven, and a one-cycle completion pulse is given. The outputs are the control levels for the amplifier's register block. The comparator flag arrives asynchronously and passes through a two-flop synchronizer before it is used.

Top module: `otc_cal_seq`

## Requirements
- R1: After reset all control outputs (`amp_en_o`, `user_trim_o`, `cal_en_o`, `ref_sel_o`, both trim codes, both fail flags, `busy_o`, `done_o`) are 0.
- R2: A start pulse seen in idle sets `amp_en_o` at that clock edge. `user_trim_o` follows one cycle later and `cal_en_o` one cycle after that. Each rises only once the ones before it are already high.
- R3: The first sweep calibrates the N pair with `ref_sel_o` = 2'b11 (high reference). `trim_n_o` starts at 0 and only ever stays or rises by one, and the stored value is the first code whose settled flag reads 0.
- R4: The second sweep calibrates the P pair the same way with `ref_sel_o` = 2'b01 (low reference) and `trim_p_o`. `trim_n_o` does not move during it.
- R5: Each code is held for `settle_cycles_i`+1 cycles before the flag is judged, so a full run lasts 5 + (settle+1)×(codes tried on N + codes tried on P) cycles from the start edge to the done edge.
- R6: If the flag still reads 1 at code 31, that pair's fail flag (`fail_n_o` or `fail_p_o`) is set and its code stays 31.
- R7: On completion `cal_en_o` is 0, `user_trim_o` and `amp_en_o` stay 1, both codes hold their results, `ref_sel_o` stays 2'b01, and `done_o` is high for exactly one cycle.
- R8: A start pulse while `busy_o` is high is ignored: the run neither restarts nor lengthens, and it produces one done pulse only.
- R9: The settling count is captured at start, so changing `settle_cycles_i` during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only in idle |
| settle_cycles_i | input | SETTLE_W | Settling cycles per trim step, captured at start |
| cmp_flag_i | input | 1 | Asynchronous comparator flag (1: non-inverting above inverting) |
| amp_en_o | output | 1 | Amplifier enable |
| user_trim_o | output | 1 | Use user trim codes instead of factory values |
| cal_en_o | output | 1 | Calibration mode: both inputs on internal reference |
| ref_sel_o | output | 2 | Reference level select (11 high, 01 low) |
| trim_n_o | output | TRIM_W | N-pair trim code |
| trim_p_o | output | TRIM_W | P-pair trim code |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_n_o | output | 1 | N sweep reached the top code without a low flag |
| fail_p_o | output | 1 | P sweep reached the top code without a low flag |

## Verification
The properties take for granted that the comparator flag is a settled function of the trim code currently driven and of the selected reference. They also assume the settling count is at least 2, so that the synchronizer has delivered the flag for the current code when it is judged. The stimulus models the comparator as a step threshold on whichever trim code belongs to the selected reference. It uses only settling counts from 2 to 5 and changes the threshold only between runs. Thresholds of 0, mid-range values, 31 and values beyond the code range cover the immediate stop, the normal stop and both fail paths.

// File: rtl/otc_pkg.sv
package otc_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_UTRIM  = 3'd1,
        ST_CALEN  = 3'd2,
        ST_REF    = 3'd3,
        ST_SETTLE = 3'd4,
        ST_FINISH = 3'd5
    } seq_state_e;

    // Differential pair under calibration
    typedef enum logic {
        PAIR_N = 1'b0,
        PAIR_P = 1'b1
    } pair_e;

    localparam int REF_SEL_W = 2;

endpackage

// File: rtl/otc_flag_sync.sv
module otc_flag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic stage_q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q <= 1'b0;
                else         stage_q <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q <= 1'b0;
                else         stage_q <= g_stage[g-1].stage_q;
            end
        end
    end

    assign sync_o = g_stage[STAGES-1].stage_q;

endmodule

// File: rtl/otc_settle_timer.sv
module otc_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/otc_ref_map.sv
module otc_ref_map
    import otc_pkg::*;
#(
    parameter logic [REF_SEL_W-1:0] REF_HIGH = 2'b11,
    parameter logic [REF_SEL_W-1:0] REF_LOW  = 2'b01
) (
    input  pair_e                pair_i,
    output logic [REF_SEL_W-1:0] ref_sel_o
);

    // N pair is calibrated near the top rail, P pair near the bottom rail
    always_comb begin
        unique case (pair_i)
            PAIR_N:  ref_sel_o = REF_HIGH;
            PAIR_P:  ref_sel_o = REF_LOW;
            default: ref_sel_o = REF_HIGH;
        endcase
    end

endmodule

// File: rtl/otc_cal_seq.sv
module otc_cal_seq
    import otc_pkg::*;
#(
    parameter int TRIM_W   = 5,
    parameter int SETTLE_W = 8,
    parameter int SYNC_STG = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [SETTLE_W-1:0]  settle_cycles_i,
    input  logic                 cmp_flag_i,
    output logic                 amp_en_o,
    output logic                 user_trim_o,
    output logic                 cal_en_o,
    output logic [REF_SEL_W-1:0] ref_sel_o,
    output logic [TRIM_W-1:0]    trim_n_o,
    output logic [TRIM_W-1:0]    trim_p_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 fail_n_o,
    output logic                 fail_p_o
);

    localparam logic [TRIM_W-1:0] CODE_MAX = {TRIM_W{1'b1}};

    typedef struct packed {
        seq_state_e            state;
        pair_e                 pair;
        logic                  amp_en;
        logic                  user_trim;
        logic                  cal_en;
        logic [REF_SEL_W-1:0]  ref_sel;
        logic [TRIM_W-1:0]     trim_n;
        logic [TRIM_W-1:0]     trim_p;
        logic                  fail_n;
        logic                  fail_p;
        logic                  done;
        logic [SETTLE_W-1:0]   settle;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic                 flag_sync;
    logic                 tmr_load;
    logic                 tmr_expired;
    logic [REF_SEL_W-1:0] pair_ref;
    logic [TRIM_W-1:0]    cur_code;

    otc_flag_sync #(
        .STAGES (SYNC_STG)
    ) u_sync (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .async_i (cmp_flag_i),
        .sync_o  (flag_sync)
    );

    otc_settle_timer #(
        .CNT_W (SETTLE_W)
    ) u_timer (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .load_i     (tmr_load),
        .load_val_i (seq_q.settle),
        .expired_o  (tmr_expired)
    );

    otc_ref_map u_ref (
        .pair_i    (seq_q.pair),
        .ref_sel_o (pair_ref)
    );

    assign cur_code = (seq_q.pair == PAIR_N) ? seq_q.trim_n : seq_q.trim_p;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        tmr_load   = 1'b0;

        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.state     = ST_UTRIM;
                    seq_d.pair      = PAIR_N;
                    seq_d.amp_en    = 1'b1;
                    seq_d.user_trim = 1'b0;
                    seq_d.cal_en    = 1'b0;
                    seq_d.ref_sel   = '0;
                    seq_d.trim_n    = '0;
                    seq_d.trim_p    = '0;
                    seq_d.fail_n    = 1'b0;
                    seq_d.fail_p    = 1'b0;
                    seq_d.settle    = settle_cycles_i;
                end
            end

            ST_UTRIM: begin
                seq_d.user_trim = 1'b1;
                seq_d.state     = ST_CALEN;
            end

            ST_CALEN: begin
                seq_d.cal_en = 1'b1;
                seq_d.state  = ST_REF;
            end

            ST_REF: begin
                // the trim code of the pair is already 0 here
                seq_d.ref_sel = pair_ref;
                tmr_load      = 1'b1;
                seq_d.state   = ST_SETTLE;
            end

            ST_SETTLE: begin
                if (tmr_expired) begin
                    if (flag_sync && (cur_code != CODE_MAX)) begin
                        // still high: next code, restart the settling window
                        if (seq_q.pair == PAIR_N) seq_d.trim_n = seq_q.trim_n + 1'b1;
                        else                      seq_d.trim_p = seq_q.trim_p + 1'b1;
                        tmr_load = 1'b1;
                    end else begin
                        // flag low: keep code; high at top code: fail and keep top
                        if (flag_sync) begin
                            if (seq_q.pair == PAIR_N) seq_d.fail_n = 1'b1;
                            else                      seq_d.fail_p = 1'b1;
                        end
                        if (seq_q.pair == PAIR_N) begin
                            seq_d.pair  = PAIR_P;
                            seq_d.state = ST_REF;
                        end else begin
                            seq_d.state = ST_FINISH;
                        end
                    end
                end
            end

            ST_FINISH: begin
                seq_d.cal_en = 1'b0;
                seq_d.done   = 1'b1;
                seq_d.state  = ST_IDLE;
            end

            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign amp_en_o    = seq_q.amp_en;
    assign user_trim_o = seq_q.user_trim;
    assign cal_en_o    = seq_q.cal_en;
    assign ref_sel_o   = seq_q.ref_sel;
    assign trim_n_o    = seq_q.trim_n;
    assign trim_p_o    = seq_q.trim_p;
    assign busy_o      = (seq_q.state != ST_IDLE);
    assign done_o      = seq_q.done;
    assign fail_n_o    = seq_q.fail_n;
    assign fail_p_o    = seq_q.fail_p;

endmodule

// File: rtl/otc_cal_seq_chk.sv
module otc_cal_seq_chk #(
    parameter int TRIM_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              amp_en_o,
    input logic              user_trim_o,
    input logic              cal_en_o,
    input logic [1:0]        ref_sel_o,
    input logic [TRIM_W-1:0] trim_n_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              fail_n_o
);

    // R2
    cal_en_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_en_o) |-> (user_trim_o && amp_en_o));

    // R3
    trim_n_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |->
            ((trim_n_o == $past(trim_n_o)) || (trim_n_o == $past(trim_n_o) + 1'b1)));

    // R4
    trim_n_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_en_o && $past(cal_en_o) && (ref_sel_o == 2'b01)) |-> $stable(trim_n_o));

    // R6
    fail_n_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_n_o |-> (trim_n_o == {TRIM_W{1'b1}}));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cal_en_o && user_trim_o && amp_en_o && !busy_o));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

endmodule

bind otc_cal_seq otc_cal_seq_chk #(
    .TRIM_W (TRIM_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .amp_en_o    (amp_en_o),
    .user_trim_o (user_trim_o),
    .cal_en_o    (cal_en_o),
    .ref_sel_o   (ref_sel_o),
    .trim_n_o    (trim_n_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_n_o    (fail_n_o)
);

// File: tb/test_otc_cal_seq.sv
module test_otc_cal_seq;

    localparam int TRIM_W   = 5;
    localparam int SETTLE_W = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [SETTLE_W-1:0] settle_i = 8'd3;
    logic                cmp;
    logic                amp_en_o, user_trim_o, cal_en_o, busy_o, done_o, fail_n_o, fail_p_o;
    logic [1:0]          ref_sel_o;
    logic [TRIM_W-1:0]   trim_n_o, trim_p_o;

    int tn_cur = 0;
    int tp_cur = 0;
    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    logic prev_done = 1'b0;

    typedef struct {
        int exp_n;
        int exp_p;
        bit fn;
        bit fp;
        int cycles;
        int c0;
    } exp_t;

    exp_t q_exp[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // comparator model: high while the active code is below its threshold
    always_comb begin
        if (ref_sel_o == 2'b11) cmp = (int'(trim_n_o) < tn_cur);
        else                    cmp = (int'(trim_p_o) < tp_cur);
    end

    otc_cal_seq #(
        .TRIM_W   (TRIM_W),
        .SETTLE_W (SETTLE_W)
    ) i_otc_cal_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start),
        .settle_cycles_i (settle_i),
        .cmp_flag_i      (cmp),
        .amp_en_o        (amp_en_o),
        .user_trim_o     (user_trim_o),
        .cal_en_o        (cal_en_o),
        .ref_sel_o       (ref_sel_o),
        .trim_n_o        (trim_n_o),
        .trim_p_o        (trim_p_o),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .fail_n_o        (fail_n_o),
        .fail_p_o        (fail_p_o)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pops the expected result on each done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) chk(!done_o, "R7", "done pulse width", int'(done_o), 0);
            if (done_o) begin
                if (q_exp.size() == 0) begin
                    chk(1'b0, "R8", "unexpected done pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = q_exp.pop_front();
                    chk(int'(trim_n_o) == e.exp_n, "R3", "N code", int'(trim_n_o), e.exp_n);
                    chk(int'(trim_p_o) == e.exp_p, "R4", "P code", int'(trim_p_o), e.exp_p);
                    chk(fail_n_o == e.fn, "R6", "N fail", int'(fail_n_o), int'(e.fn));
                    chk(fail_p_o == e.fp, "R6", "P fail", int'(fail_p_o), int'(e.fp));
                    chk((cyc - e.c0) == e.cycles, "R5", "run length", cyc - e.c0, e.cycles);
                    chk(!cal_en_o && user_trim_o && amp_en_o, "R7", "final controls",
                        {cal_en_o, user_trim_o, amp_en_o}, 3);
                    chk(ref_sel_o == 2'b01, "R4", "final reference", int'(ref_sel_o), 1);
                end
            end
            prev_done <= done_o;
        end
    end

    task automatic run_cal(int tn, int tp, int l, bit setup_chk, bit poke_busy, bit poke_settle);
        exp_t e;
        int nn, np;
        tn_cur   = tn;
        tp_cur   = tp;
        settle_i = l[SETTLE_W-1:0];
        nn = (tn > 31) ? 32 : tn + 1;
        np = (tp > 31) ? 32 : tp + 1;
        e.exp_n  = (tn > 31) ? 31 : tn;
        e.exp_p  = (tp > 31) ? 31 : tp;
        e.fn     = (tn > 31);
        e.fp     = (tp > 31);
        e.cycles = 5 + (l + 1) * (nn + np);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        e.c0 = cyc;
        q_exp.push_back(e);
        if (setup_chk) begin
            chk(amp_en_o && !user_trim_o, "R2", "step1 amp/utrim", {amp_en_o, user_trim_o}, 2);
            @(negedge clk);
            chk(user_trim_o && !cal_en_o, "R2", "step2 utrim/calen", {user_trim_o, cal_en_o}, 2);
            @(negedge clk);
            chk(cal_en_o && ref_sel_o == 2'b00, "R2", "step3 calen/ref", {cal_en_o, ref_sel_o}, 4);
            @(negedge clk);
            chk(ref_sel_o == 2'b11, "R3", "N reference", int'(ref_sel_o), 3);
            chk(trim_n_o == '0, "R3", "N start code", int'(trim_n_o), 0);
        end
        if (poke_settle) settle_i = 8'd9;   // R9: must not affect this run
        if (poke_busy) begin                // R8: start while busy
            repeat (10) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({amp_en_o, user_trim_o, cal_en_o, ref_sel_o, trim_n_o, trim_p_o,
             busy_o, done_o, fail_n_o, fail_p_o} == '0, "R1", "reset outputs", 1, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !amp_en_o, "R1", "idle after reset", int'(busy_o), 0);

        run_cal(5, 9, 3, 1'b1, 1'b0, 1'b0);
        run_cal(0, 31, 2, 1'b0, 1'b0, 1'b0);
        run_cal(40, 12, 4, 1'b0, 1'b0, 1'b0);
        run_cal(17, 40, 2, 1'b0, 1'b1, 1'b0);
        run_cal(3, 3, 5, 1'b0, 1'b0, 1'b1);

        chk(q_exp.size() == 0, "R8", "pending results", q_exp.size(), 0);
        chk(!busy_o && !done_o, "R8", "idle at end", int'(busy_o), 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R5 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule